// File: doc/BRIEF.md
# Flash Command Sequencer

This controller stands between a system bus and an on-chip flash store. It has two modes. In read mode the store answers reads directly. In command mode, bus writes are decoded as unlock sequences that ask for an array operation. Three operations exist: programming one double word, erasing one 64 KB block, and changing write protection. While an operation runs, a read does not return array data. It returns a status byte instead, which software polls to follow progress. A ready/busy level and a one-cycle ready pulse go to the interrupt logic.

The store is a behavioural model. Program and erase latencies are fixed counts set by parameters. Each segment keeps `WORD_W`-bit indexed words. In-segment address bits above the word index alias onto the same storage. The protect command never makes the block busy; it takes effect at once.

Top module: `flashCmdCtrl`

## Requirements
- R1: After reset the block is in read mode. `readyBusy` and `readyPulse` are low, no block is protected, and every stored word reads 0xFFFFFFFF.
- R2: In read mode, a read with `rdEn` returns the addressed 32-bit word on `rdData` one cycle later. Address bits 1:0 are ignored. Bits 17:16 select one of four segments, and bits 4:2 select the word inside it.
- R3: Four writes program a word: 0xAA to offset 0x5554, 0x55 to offset 0x2AAA, 0xA0 to offset 0x5554, then the data to the target address. Offsets are address bits 15:0, and commands are data bits 7:0. `readyBusy` is high for exactly `PROG_CYCLES` cycles after the last write. The word then reads as the data.
- R4: Six writes erase a block: the two unlock cycles, 0x80 at 0x5554, the two unlock cycles again, then 0x30 to any address in the block. `readyBusy` is high for `ERASE_CYCLES` cycles. Afterwards every word of that segment reads all ones and other segments are unchanged.
- R5: While an operation runs, or after a program error, each read returns a status word. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bit 3 is 1 during an erase. Bits 6 and 2 are both 0 on the first status read after a start and invert on each later status read. Bit 5 is 1 only in the error state. All other bits are 0.
- R6: `readyPulse` is high for exactly one cycle: the first cycle in which `readyBusy` is low after being high.
- R7: While `readyBusy` is high, every write is ignored except the erase suspend code. A complete program sequence issued then changes nothing.
- R8: A write whose offset or data does not match the expected step ends the sequence. The next write must restart at the first unlock cycle.
- R9: A write with data 0xF0 in any step except the program data step abandons the sequence.
- R10: Programming a 1 into a bit that holds 0 starts no operation. The array stays unchanged, and the block enters an error state with `readyBusy` low. That state is left only by a write with data 0xF0.
- R11: After the two unlock cycles, 0x60 at 0x5554 followed by a code at a block address changes protection. 0x01 protects the block, 0x00 unprotects it, 0x03 protects the whole store, and 0x02 clears whole-store protection. Program or erase aimed at a protected block does nothing and leaves the block in read mode.
- R12: While `bootMode` is high, the unprotect codes 0x00 and 0x02 have no effect.
- R13: During an erase, data 0xB0 suspends it. `readyBusy` goes low, reads return array data, and the remaining count is held. Data 0x30 resumes the erase for exactly the cycles that were left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 18 | Byte address for reads and writes |
| wrEn | input | 1 | Bus write strobe |
| wrData | input | 32 | Write data; command byte in bits 7:0 |
| rdEn | input | 1 | Bus read strobe |
| bootMode | input | 1 | High while booting; locks protection on |
| rdData | output | 32 | Registered read result: array word or status |
| readyBusy | output | 1 | High while a program or erase runs |
| readyPulse | output | 1 | One-cycle pulse when an operation ends or is suspended |

## Verification
A wrong sequence state has two visible effects. A valid command may start no operation, so `readyBusy` fails to rise in the cycle after the final write. Or a stray write may start one. A wrong cycle count shows in how many cycles `readyBusy` stays high. A wrong mode shows on the very next read, as array data where a status word belongs, or the reverse, or as toggle bits out of phase. Corrupted storage or protection state shows on a read-back sweep after each operation.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  typedef enum logic [1:0] {
    MODE_READ,
    MODE_BUSY,
    MODE_SUSP,
    MODE_ERR
  } modeT;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_UNL1,
    SEQ_UNL2,
    SEQ_PROG,
    SEQ_ERS1,
    SEQ_ERS2,
    SEQ_ERS3,
    SEQ_PROT
  } seqT;

  // control to datapath strobes
  typedef struct packed {
    logic capture;      // latch target index and data
    logic commitProg;   // write latched data into the array
    logic commitErase;  // fill latched segment with ones
    logic protOp;       // apply protect code from write data
    logic clrToggle;    // restart status toggle phase
  } strobeT;

  localparam int OFFS_W = 16;
  localparam logic [OFFS_W-1:0] OFFS_FIRST  = 16'h5554;
  localparam logic [OFFS_W-1:0] OFFS_SECOND = 16'h2AAA;

  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_GO      = 8'h30;
  localparam logic [7:0] CMD_ABORT   = 8'hF0;
  localparam logic [7:0] CMD_PROT    = 8'h60;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  localparam logic [7:0] PROT_CLR_BLK = 8'h00;
  localparam logic [7:0] PROT_SET_BLK = 8'h01;
  localparam logic [7:0] PROT_CLR_ALL = 8'h02;
  localparam logic [7:0] PROT_SET_ALL = 8'h03;

endpackage

// File: rtl/flashCmdFsm.sv
module flashCmdFsm
  import flashCmdPkg::*;
#(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [OFFS_W-1:0] wrOffs,
  input  logic [7:0]        wrCmd,
  input  logic              tgtProt,
  input  logic              wrConflict,
  output strobeT            strb,
  output modeT              mode,
  output logic              opErase
);

  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  modeT             modeQ, modeD;
  seqT              seqQ, seqD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             eraseQ, eraseD;
  logic             keyA, keyB, atFirst;

  assign keyA    = (wrOffs == OFFS_FIRST) && (wrCmd == KEY_FIRST);
  assign keyB    = (wrOffs == OFFS_SECOND) && (wrCmd == KEY_SECOND);
  assign atFirst = (wrOffs == OFFS_FIRST);

  always_comb begin
    strb   = '0;
    modeD  = modeQ;
    seqD   = seqQ;
    cntD   = cntQ;
    eraseD = eraseQ;
    unique case (modeQ)
      MODE_READ: if (wrEn) begin
        seqD = SEQ_IDLE;
        if (seqQ == SEQ_PROG) begin
          if (!tgtProt) begin
            strb.capture   = 1'b1;
            strb.clrToggle = 1'b1;
            eraseD         = 1'b0;
            if (wrConflict) modeD = MODE_ERR;
            else begin
              modeD = MODE_BUSY;
              cntD  = CNT_W'(PROG_CYCLES);
            end
          end
        end else if (wrCmd != CMD_ABORT) begin
          unique case (seqQ)
            SEQ_IDLE: if (keyA) seqD = SEQ_UNL1;
            SEQ_UNL1: if (keyB) seqD = SEQ_UNL2;
            SEQ_UNL2: if (atFirst) begin
              if (wrCmd == CMD_PROG)       seqD = SEQ_PROG;
              else if (wrCmd == CMD_ERASE) seqD = SEQ_ERS1;
              else if (wrCmd == CMD_PROT)  seqD = SEQ_PROT;
            end
            SEQ_ERS1: if (keyA) seqD = SEQ_ERS2;
            SEQ_ERS2: if (keyB) seqD = SEQ_ERS3;
            SEQ_ERS3: if (wrCmd == CMD_GO && !tgtProt) begin
              strb.capture   = 1'b1;
              strb.clrToggle = 1'b1;
              eraseD         = 1'b1;
              modeD          = MODE_BUSY;
              cntD           = CNT_W'(ERASE_CYCLES);
            end
            SEQ_PROT: strb.protOp = 1'b1;
            default: ;
          endcase
        end
      end
      MODE_BUSY: begin
        if (cntQ == CNT_W'(1)) begin
          modeD = MODE_READ;
          if (eraseQ) strb.commitErase = 1'b1;
          else        strb.commitProg  = 1'b1;
        end else if (wrEn && eraseQ && wrCmd == CMD_SUSPEND) begin
          modeD = MODE_SUSP;
        end else begin
          cntD = cntQ - CNT_W'(1);
        end
      end
      MODE_SUSP: if (wrEn && wrCmd == CMD_GO) modeD = MODE_BUSY;
      MODE_ERR:  if (wrEn && wrCmd == CMD_ABORT) modeD = MODE_READ;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_READ;
      seqQ   <= SEQ_IDLE;
      cntQ   <= '0;
      eraseQ <= 1'b0;
    end else begin
      modeQ  <= modeD;
      seqQ   <= seqD;
      cntQ   <= cntD;
      eraseQ <= eraseD;
    end
  end

  assign mode    = modeQ;
  assign opErase = eraseQ;

  // R7: no sequence progress outside read mode
  assert_seq_idle_running_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_READ) |-> (seqQ == SEQ_IDLE));

  // R3: a fresh start loads the full latency of its operation
  assert_start_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_BUSY && $past(modeQ) == MODE_READ) |->
      (cntQ == (eraseQ ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES))));

  // R6: a commit always lands back in read mode
  assert_commit_to_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitProg || strb.commitErase) |=> (modeQ == MODE_READ));

  // R13: only an erase can be suspended, and its count is held
  assert_suspend_erase_R13: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SUSP) |=> (eraseQ && $stable(cntQ)));

  // R4: counter never exceeds the longest latency
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(MAX_CYC));

endmodule

// File: rtl/flashArrayPath.sv
module flashArrayPath
  import flashCmdPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEG_W  = 2,
  parameter int WORD_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEG_W-1:0]  seg,
  input  logic [WORD_W-1:0] word,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              bootMode,
  input  strobeT            strb,
  input  modeT              mode,
  input  logic              opErase,
  output logic              tgtProt,
  output logic              wrConflict,
  output logic [DATA_W-1:0] rdData
);

  localparam int IDX_W  = SEG_W + WORD_W;
  localparam int NWORDS = 1 << IDX_W;
  localparam int NSEGS  = 1 << SEG_W;

  logic [DATA_W-1:0] mem [NWORDS];
  logic [NSEGS-1:0]  blkProtQ;
  logic              allProtQ;
  logic [IDX_W-1:0]  opIdxQ;
  logic [DATA_W-1:0] opDataQ;
  logic              toggleQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [IDX_W-1:0]  curIdx;
  logic              statusSel;
  logic [DATA_W-1:0] statusWord;

  assign curIdx     = {seg, word};
  assign tgtProt    = allProtQ | blkProtQ[seg];
  assign wrConflict = |(wrData & ~mem[curIdx]);
  assign statusSel  = (mode == MODE_BUSY) || (mode == MODE_ERR);

  always_comb begin
    statusWord    = '0;
    statusWord[7] = opErase ? 1'b0 : ~opDataQ[7];
    statusWord[6] = toggleQ;
    statusWord[5] = (mode == MODE_ERR);
    statusWord[3] = opErase;
    statusWord[2] = toggleQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < NWORDS; i++) begin
        if (strb.commitErase && ((IDX_W'(i) >> WORD_W) == (opIdxQ >> WORD_W)))
          mem[i] <= '1;
        else if (strb.commitProg && (IDX_W'(i) == opIdxQ))
          mem[i] <= opDataQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkProtQ <= '0;
      allProtQ <= 1'b0;
      opIdxQ   <= '0;
      opDataQ  <= '0;
      toggleQ  <= 1'b0;
      rdDataQ  <= '0;
    end else begin
      if (strb.protOp) begin
        unique case (wrData[7:0])
          PROT_SET_BLK: blkProtQ[seg] <= 1'b1;
          PROT_CLR_BLK: if (!bootMode) blkProtQ[seg] <= 1'b0;
          PROT_SET_ALL: allProtQ <= 1'b1;
          PROT_CLR_ALL: if (!bootMode) allProtQ <= 1'b0;
          default: ;
        endcase
      end
      if (strb.capture) begin
        opIdxQ  <= curIdx;
        opDataQ <= wrData;
      end
      if (rdEn) begin
        if (statusSel) begin
          rdDataQ <= statusWord;
          toggleQ <= ~toggleQ;
        end else begin
          rdDataQ <= mem[curIdx];
        end
      end
      if (strb.clrToggle) toggleQ <= 1'b0;
    end
  end

  assign rdData = rdDataQ;

  // R5: status reads carry only the five defined bits
  assert_status_reserved_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && statusSel) |=>
      (rdDataQ[DATA_W-1:8] == '0 && rdDataQ[4] == 1'b0 && rdDataQ[1:0] == 2'b00));

  // R10: a committed program never raises a bit
  assert_prog_only_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitProg |-> ((opDataQ & ~mem[opIdxQ]) == '0));

  // R11: nothing is committed into a protected segment
  assert_no_protected_commit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitProg || strb.commitErase) |->
      !(allProtQ || blkProtQ[opIdxQ[IDX_W-1 -: SEG_W]]));

  // R12: unprotect codes are inert while booting
  assert_boot_keeps_prot_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.protOp && bootMode &&
     (wrData[7:0] == PROT_CLR_BLK || wrData[7:0] == PROT_CLR_ALL))
      |=> ($stable(blkProtQ) && $stable(allProtQ)));

endmodule

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flashCmdPkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 32,
  parameter int WORD_W       = 3,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              bootMode,
  output logic [DATA_W-1:0] rdData,
  output logic              readyBusy,
  output logic              readyPulse
);

  localparam int SEG_W = ADDR_W - OFFS_W;

  strobeT strb;
  modeT   mode;
  logic   opErase, tgtProt, wrConflict, busyPrevQ;

  flashCmdFsm #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) i_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrOffs    (addr[OFFS_W-1:0]),
    .wrCmd     (wrData[7:0]),
    .tgtProt   (tgtProt),
    .wrConflict(wrConflict),
    .strb      (strb),
    .mode      (mode),
    .opErase   (opErase)
  );

  flashArrayPath #(
    .DATA_W(DATA_W),
    .SEG_W (SEG_W),
    .WORD_W(WORD_W)
  ) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .seg       (addr[ADDR_W-1 -: SEG_W]),
    .word      (addr[WORD_W+1:2]),
    .wrData    (wrData),
    .rdEn      (rdEn),
    .bootMode  (bootMode),
    .strb      (strb),
    .mode      (mode),
    .opErase   (opErase),
    .tgtProt   (tgtProt),
    .wrConflict(wrConflict),
    .rdData    (rdData)
  );

  assign readyBusy = (mode == MODE_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyPrevQ <= 1'b0;
    else       busyPrevQ <= readyBusy;
  end

  assign readyPulse = busyPrevQ & ~readyBusy;

  // R6: the ready pulse never lasts two cycles
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |=> !readyPulse);

endmodule

// File: tb/test_flashCmdCtrl.sv
module test_flashCmdCtrl;

  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 8;
  localparam int ERASE_CYC  = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic        bootMode = 1'b0;
  logic [31:0] rdData;
  logic        readyBusy, readyPulse;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];

  flashCmdCtrl #(.PROG_CYCLES(PROG_CYC), .ERASE_CYCLES(ERASE_CYC)) i_flashCmdCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .bootMode(bootMode), .rdData(rdData),
    .readyBusy(readyBusy), .readyPulse(readyPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual running expected done");
    finishRun();
  end

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] adr(int seg, int w, int off);
    return {seg[1:0], 11'd0, w[2:0], off[1:0]};
  endfunction

  task automatic busWrite(logic [17:0] a, logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [17:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic unlock();
    busWrite(18'h05554, 32'hAA);
    busWrite(18'h02AAA, 32'h55);
  endtask

  task automatic progCmd(logic [17:0] a, logic [31:0] d);
    unlock();
    busWrite(18'h05554, 32'hA0);
    busWrite(a, d);
  endtask

  task automatic eraseCmd(int seg);
    unlock();
    busWrite(18'h05554, 32'h80);
    unlock();
    busWrite(adr(seg, 2, 1), 32'h30);
  endtask

  task automatic protCmd(int seg, logic [7:0] code);
    unlock();
    busWrite(18'h05554, 32'h60);
    busWrite(adr(seg, 0, 0), {24'd0, code});
  endtask

  task automatic waitReady(output int cyc, output logic pulse);
    cyc = 0;
    while (readyBusy) begin
      cyc++;
      @(negedge clk);
    end
    pulse = readyPulse;
  endtask

  task automatic sweep(string req);
    logic [31:0] d;
    for (int i = 0; i < 32; i++) begin
      busRead(adr(i / 8, i % 8, i % 4), d);
      checkEq(req, d, model[i]);
    end
  endtask

  initial begin
    logic [31:0] d, nd;
    int cyc;
    logic pulse;

    for (int i = 0; i < 32; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkEq("R1 readyBusy", {31'd0, readyBusy}, 32'd0);
    checkEq("R1 readyPulse", {31'd0, readyPulse}, 32'd0);
    sweep("R1 erased contents");

    // R3 R6: program every word with an arithmetic pattern
    for (int i = 0; i < 32; i++) begin
      nd = (32'h01010101 * i) ^ 32'h5A3C0F00 ^ (i << 20);
      progCmd(adr(i / 8, i % 8, 3 - (i % 4)), nd);
      checkEq("R6 busy after start", {31'd0, readyBusy}, 32'd1);
      waitReady(cyc, pulse);
      checkEq("R3 program latency", cyc, PROG_CYC);
      checkEq("R6 ready pulse", {31'd0, pulse}, 32'd1);
      @(negedge clk);
      checkEq("R6 pulse one cycle", {31'd0, readyPulse}, 32'd0);
      model[i] = nd;
    end
    sweep("R2 R3 readback");

    // R5: status during program
    nd = model[0] & 32'h1234_5678;
    progCmd(adr(0, 0, 0), nd);
    busRead(adr(0, 0, 0), d);
    checkEq("R5 first program status", d, {24'd0, ~nd[7], 7'd0});
    busRead(adr(0, 0, 0), d);
    checkEq("R5 second program status", d, {24'd0, ~nd[7], 7'h44});
    waitReady(cyc, pulse);
    model[0] = nd;
    busRead(adr(0, 0, 2), d);
    checkEq("R5 true value after end", d, nd);

    // R7: program sequence while busy is ignored
    progCmd(adr(0, 1, 0), model[1] & 32'hFFFF_0000);
    progCmd(adr(0, 2, 0), 32'd0);
    waitReady(cyc, pulse);
    model[1] = model[1] & 32'hFFFF_0000;
    busRead(adr(0, 2, 0), d);
    checkEq("R7 busy write ignored", d, model[2]);
    busRead(adr(0, 1, 0), d);
    checkEq("R7 first program kept", d, model[1]);

    // R4 R5: erase block 1 with status reads
    eraseCmd(1);
    busRead(0, d);
    checkEq("R5 first erase status", d, 32'h08);
    busRead(0, d);
    checkEq("R5 second erase status", d, 32'h4C);
    waitReady(cyc, pulse);
    checkEq("R4 erase latency", cyc, ERASE_CYC - 2);
    for (int w = 0; w < 8; w++) model[8 + w] = '1;
    sweep("R4 erase block only");

    // R13: suspend and resume erase of block 2
    eraseCmd(2);
    repeat (3) @(negedge clk);
    busWrite(0, 32'hB0);
    checkEq("R13 suspended not busy", {31'd0, readyBusy}, 32'd0);
    checkEq("R13 suspend pulse", {31'd0, readyPulse}, 32'd1);
    busRead(adr(2, 4, 0), d);
    checkEq("R13 array read while suspended", d, model[20]);
    busWrite(0, 32'h30);
    checkEq("R13 resumed busy", {31'd0, readyBusy}, 32'd1);
    waitReady(cyc, pulse);
    checkEq("R13 remaining cycles", cyc, ERASE_CYC - 3);
    for (int w = 0; w < 8; w++) model[16 + w] = '1;
    sweep("R13 erase after resume");

    // R8: wrong address then wrong data
    unlock();
    busWrite(18'h01234, 32'hA0);
    busWrite(adr(3, 1, 0), 32'd0);
    checkEq("R8 bad address no start", {31'd0, readyBusy}, 32'd0);
    busWrite(18'h05554, 32'hAA);
    busWrite(18'h02AAA, 32'h56);
    busWrite(18'h05554, 32'hA0);
    busWrite(adr(3, 1, 0), 32'd0);
    checkEq("R8 bad data no start", {31'd0, readyBusy}, 32'd0);
    busRead(adr(3, 1, 0), d);
    checkEq("R8 word unchanged", d, model[25]);
    progCmd(adr(3, 1, 0), 32'd0);
    waitReady(cyc, pulse);
    model[25] = 32'd0;
    busRead(adr(3, 1, 0), d);
    checkEq("R8 restart works", d, 32'd0);

    // R9: abort mid sequence
    unlock();
    busWrite(18'h05554, 32'hF0);
    busWrite(18'h05554, 32'hA0);
    busWrite(adr(3, 2, 0), 32'd0);
    checkEq("R9 abort no start", {31'd0, readyBusy}, 32'd0);
    busRead(adr(3, 2, 0), d);
    checkEq("R9 word unchanged", d, model[26]);

    // R10: programming a zero bit back to one
    progCmd(adr(3, 1, 0), 32'h0000_0080);
    checkEq("R10 error not busy", {31'd0, readyBusy}, 32'd0);
    busRead(0, d);
    checkEq("R10 error status first", d, 32'h20);
    busRead(0, d);
    checkEq("R10 error status second", d, 32'h64);
    busWrite(18'h05554, 32'hAA);
    busRead(0, d);
    checkEq("R10 error held", d, 32'h20);
    busWrite(0, 32'hF0);
    busRead(adr(3, 1, 0), d);
    checkEq("R10 array unchanged", d, 32'd0);

    // R11: block and whole-store protection
    protCmd(3, 8'h01);
    progCmd(adr(3, 3, 0), 32'd0);
    checkEq("R11 protected program", {31'd0, readyBusy}, 32'd0);
    eraseCmd(3);
    checkEq("R11 protected erase", {31'd0, readyBusy}, 32'd0);
    busRead(adr(3, 3, 0), d);
    checkEq("R11 protected word", d, model[27]);
    protCmd(3, 8'h00);
    progCmd(adr(3, 3, 0), 32'd0);
    checkEq("R11 unprotected runs", {31'd0, readyBusy}, 32'd1);
    waitReady(cyc, pulse);
    model[27] = 32'd0;
    protCmd(0, 8'h03);
    progCmd(adr(1, 4, 0), 32'd0);
    checkEq("R11 all protected", {31'd0, readyBusy}, 32'd0);
    protCmd(0, 8'h02);
    progCmd(adr(1, 4, 0), 32'd0);
    waitReady(cyc, pulse);
    model[12] = 32'd0;
    sweep("R11 contents");

    // R12: boot mode keeps protection
    bootMode = 1'b1;
    protCmd(2, 8'h01);
    protCmd(2, 8'h00);
    progCmd(adr(2, 5, 0), 32'd0);
    checkEq("R12 block unprotect ignored", {31'd0, readyBusy}, 32'd0);
    protCmd(0, 8'h03);
    protCmd(0, 8'h02);
    progCmd(adr(1, 5, 0), 32'd0);
    checkEq("R12 all unprotect ignored", {31'd0, readyBusy}, 32'd0);
    bootMode = 1'b0;
    protCmd(0, 8'h02);
    protCmd(2, 8'h00);
    progCmd(adr(2, 5, 0), 32'd0);
    checkEq("R12 unprotect after boot", {31'd0, readyBusy}, 32'd1);
    waitReady(cyc, pulse);
    model[21] = 32'd0;
    sweep("R12 contents");

    finishRun();
  end

endmodule